// File: doc/BRIEF.md
# Processor Status and Reset-Cause Register

This block is the eight-bit status and control register of a small microcontroller core. Firmware reads it to learn why the core last restarted: a watchdog rollover, a low-voltage or brown-out condition, or a power-on. The same register carries a pending-interrupt flag and a latched bus-activity event. It also mirrors the global interrupt-enable state and controls the suspend and run/halt states of the core.

The register is built from event inputs. The watchdog timer and the supply monitor each deliver a one-cycle pulse. A 128 µs timebase tick qualifies the raw bus-activity level. The instruction decoder pulses the halt, enable-interrupt, disable-interrupt and return-from-interrupt inputs. The interrupt controller provides the request, the per-source enable and the wake condition.

The block drives four outputs:
- the readback word;
- a suspend request to the clock controller;
- a run flag;
- a one-cycle interrupt-acknowledge strobe that starts the interrupt handling sequence.

The watchdog counter, the bus-protocol decoding and the oscillator are outside the block.

Top module: `sysctl_status`

## Requirements
- R1: After the synchronous active-low reset `rst_n` the readback is 0x11 (bit 4 low-voltage cause = 1, bit 0 run = 1, all other bits 0), `suspend_o` is 0 and `irq_ack` is 0.
- R2: A `wdt_roll` pulse without `lv_evt` sets bit 6 (watchdog cause), leaves bit 4 unchanged, clears bit 5 and forces run to 1 on the next cycle.
- R3: An `lv_evt` pulse sets bit 4, clears bits 6, 5, 7 and 2, ends suspend and forces run to 1 on the next cycle. It takes precedence over a simultaneous `wdt_roll`, so bit 6 reads 0.
- R4: A firmware write of 0 to bit 6, 5 or 4 clears that bit, and a write of 1 to them leaves them unchanged. Writes to bits 7, 2 and 1 have no effect, and bit 1 always reads 0.
- R5: Bit 5 (bus event) sets on the edge of the `QUAL_TICKS`-th `tick_128` (default 2) seen while `bus_lvl` stays high without a break. It sets regardless of `src_en`. A low `bus_lvl` restarts the count, and one continuous assertion latches the bit at most once.
- R6: Bit 5 is cleared only by a firmware write of 0, a `wdt_roll` or an `lv_evt`. A qualification that completes in the same cycle as a firmware clear leaves bit 5 set.
- R7: An `irq_req` pulse sets bit 7 (pending), which stays set while `src_en` or the global enable (bit 2) is 0.
- R8: At a clock edge where pending, `src_en` and bit 2 are all 1, the block takes the interrupt. On the next cycle `irq_ack` is 1 for exactly one cycle and bits 7 and 2 read 0. A new `irq_req` on that same edge keeps bit 7 set.
- R9: `ei_op` and `reti_op` set bit 2 and `di_op` clears it. `di_op` wins when it arrives together with either of the others, and firmware writes to bit 2 have no effect.
- R10: A firmware write with bit 3 = 1 sets bit 3 and `suspend_o` on the next cycle. If `wake_req` is sampled while suspended, both fall exactly `WAKE_CYCLES` (default 4) edges later. Without a wake they stay at 1.
- R11: If `wake_req` is already high when suspend is written, suspend is still entered, and `suspend_o` is 1 for exactly `WAKE_CYCLES`+1 cycles.
- R12: `halt_op`, or a firmware write of 0 to bit 0, clears run (bit 0 and `run_o`). Run stays 0 (a firmware write of 1 does not set it) until a `wdt_roll` or `lv_evt` occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wr_en | input | 1 | Firmware write strobe for the register |
| wr_data | input | 8 | Firmware write data |
| rd_data | output | 8 | Register readback |
| wdt_roll | input | 1 | Watchdog rollover pulse |
| lv_evt | input | 1 | Low-voltage / brown-out reset pulse |
| bus_lvl | input | 1 | Raw bus-activity level |
| tick_128 | input | 1 | One-cycle 128 µs timebase tick |
| halt_op | input | 1 | Halt instruction pulse |
| ei_op | input | 1 | Enable-interrupt instruction pulse |
| di_op | input | 1 | Disable-interrupt instruction pulse |
| reti_op | input | 1 | Return-from-interrupt instruction pulse |
| irq_req | input | 1 | Interrupt request pulse |
| src_en | input | 1 | Enable of the requesting interrupt source |
| wake_req | input | 1 | Wake condition (interrupt or bus activity) |
| suspend_o | output | 1 | Suspend request to the clock controller |
| run_o | output | 1 | Core run flag |
| irq_ack | output | 1 | One-cycle interrupt-acknowledge strobe |

## Verification
Some rules are checked by assertions on every cycle:
- how the reset causes take precedence over each other;
- that a halt is held until a reset cause arrives;
- that the acknowledge lasts one cycle and leaves interrupts disabled;
- that the suspend state is held until a wake;
- that a qualified bus event is always preceded by a sampled high level.

The exact cycle on which suspend is released is shown only by the bench scenarios. The same holds for the second-tick latching of the bus event and its restart after a gap, for a wake that is present at the moment of entry, and for firmware writes that must leave bits untouched. The bench also compares every output field against its own cycle model under mixed random traffic.

// File: rtl/sysstat_pkg.sv
// Package: shared field positions and state encoding of the processor
// status register. Field positions are firmware-visible and fixed.
package sysstat_pkg;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned B_PEND = 7;
    localparam int unsigned B_WDOG = 6;
    localparam int unsigned B_BUSE = 5;
    localparam int unsigned B_LOWV = 4;
    localparam int unsigned B_SUSP = 3;
    localparam int unsigned B_IEN  = 2;
    localparam int unsigned B_RSVD = 1;
    localparam int unsigned B_RUN  = 0;

    typedef enum logic [1:0] {
        WK_AWAKE  = 2'd0,
        WK_SLEEP  = 2'd1,
        WK_WARMUP = 2'd2
    } wake_st_t;
endpackage

// File: rtl/sst_busqual.sv
// Module: sst_busqual
// Qualifies a raw bus-activity level with a slow timebase tick. Emits a
// one-cycle fire pulse on the TICKS-th tick seen while the level stays
// high without a break; fires at most once per continuous assertion.
// Assumes lvl and tick are synchronous to clk and TICKS >= 2.
module sst_busqual #(
    parameter int unsigned TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic lvl,
    input  logic tick,
    output logic fire
);
    localparam int unsigned CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
    localparam logic [CW-1:0] FULL = CW'(TICKS);

    logic [CW-1:0] cnt_q;

    // Count ticks during an unbroken high level, saturating at FULL.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !lvl) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != FULL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Fire when the final qualifying tick arrives.
    always_comb begin
        fire = lvl && tick && !clr && (cnt_q == LAST);
    end

    // R5: a qualified event needs the level high on the previous cycle too
    a_r5_level_persisted: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(lvl));
endmodule

// File: rtl/sst_wake.sv
// Module: sst_wake
// Suspend sequencer. Enters sleep on a firmware request, waits for a wake
// condition, then holds the suspend request for CYCLES start-up edges
// before releasing it. A wake already present at entry is taken on the
// first edge after entry. Assumes CYCLES >= 1.
module sst_wake
    import sysstat_pkg::*;
#(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic enter,
    input  logic wake,
    output logic asleep
);
    localparam int unsigned WW = $clog2(CYCLES + 1);
    localparam logic [WW-1:0] LOAD = WW'(CYCLES - 1);

    wake_st_t      st_q;
    logic [WW-1:0] cnt_q;

    // Sleep / start-up state machine with its delay counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st_q  <= WK_AWAKE;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                WK_AWAKE: begin
                    if (enter) st_q <= WK_SLEEP;
                end
                WK_SLEEP: begin
                    if (wake) begin
                        st_q  <= WK_WARMUP;
                        cnt_q <= LOAD;
                    end
                end
                WK_WARMUP: begin
                    if (cnt_q == '0) st_q <= WK_AWAKE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= WK_AWAKE;
            endcase
        end
    end

    // Suspend is requested in every state except awake.
    always_comb begin
        asleep = (st_q != WK_AWAKE);
    end

    // R10: without a wake the block stays asleep
    a_r10_sleep_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WK_SLEEP && !wake && !clr) |=> (st_q == WK_SLEEP));
    // R10: suspend is not released before the start-up count has run out
    a_r10_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WK_WARMUP && cnt_q != '0 && !clr) |=> asleep);
    // R11: start-up count never exceeds its load value
    a_r11_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WK_WARMUP) |-> (cnt_q <= LOAD));
endmodule

// File: rtl/sst_irq.sv
// Module: sst_irq
// Interrupt pending flag, global enable mirror and acknowledge strobe.
// An interrupt is taken on an edge where pending, source enable and
// global enable are all set; taking it clears pending and the global
// enable and raises a one-cycle acknowledge. clr is a hardware reset cause.
module sst_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic irq_req,
    input  logic src_en,
    input  logic ei,
    input  logic di,
    input  logic reti,
    output logic pend,
    output logic ien,
    output logic ack
);
    logic take;

    // Decide whether the interrupt is taken on this edge.
    always_comb begin
        take = pend && src_en && ien;
    end

    // Pending flag: a new request wins over the clear from taking it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  pend <= 1'b0;
        else if (irq_req)   pend <= 1'b1;
        else if (take)      pend <= 1'b0;
    end

    // Global enable: taking and disabling win over enabling.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)     ien <= 1'b0;
        else if (take || di)   ien <= 1'b0;
        else if (ei || reti)   ien <= 1'b1;
    end

    // Acknowledge strobe, one cycle after the taking edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) ack <= 1'b0;
        else               ack <= take;
    end

    // R8: acknowledge is always seen with interrupts disabled
    a_r8_ack_masks: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !ien);
    // R8: acknowledge lasts a single cycle
    a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R9: disable instruction always leaves interrupts masked
    a_r9_di_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (di && !clr) |=> !ien);
    // R7: pending stays while it cannot be taken
    a_r7_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !(src_en && ien) && !clr) |=> pend);
endmodule

// File: rtl/sysctl_status.sv
// Module: sysctl_status (top)
// Processor status and reset-cause register. Holds the sticky reset-cause
// bits, the qualified bus-event bit and the run flag, and assembles the
// readback from them and the interrupt and suspend sub-blocks.
// Assumes all event inputs are synchronous single-cycle pulses except
// bus_lvl, src_en and wake_req, which are levels.
module sysctl_status
    import sysstat_pkg::*;
#(
    parameter int unsigned QUAL_TICKS  = 2,
    parameter int unsigned WAKE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             wdt_roll,
    input  logic             lv_evt,
    input  logic             bus_lvl,
    input  logic             tick_128,
    input  logic             halt_op,
    input  logic             ei_op,
    input  logic             di_op,
    input  logic             reti_op,
    input  logic             irq_req,
    input  logic             src_en,
    input  logic             wake_req,
    output logic             suspend_o,
    output logic             run_o,
    output logic             irq_ack
);
    logic hw_rst;
    logic bus_fire;
    logic wdog_q, buse_q, lowv_q, run_q;
    logic pend, ien, asleep;

    // Either hardware reset cause re-initialises the core state.
    always_comb begin
        hw_rst = wdt_roll || lv_evt;
    end

    sst_busqual #(.TICKS(QUAL_TICKS)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hw_rst),
        .lvl   (bus_lvl),
        .tick  (tick_128),
        .fire  (bus_fire)
    );

    sst_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hw_rst),
        .irq_req (irq_req),
        .src_en  (src_en),
        .ei      (ei_op),
        .di      (di_op),
        .reti    (reti_op),
        .pend    (pend),
        .ien     (ien),
        .ack     (irq_ack)
    );

    sst_wake #(.CYCLES(WAKE_CYCLES)) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (hw_rst),
        .enter  (wr_en && wr_data[B_SUSP]),
        .wake   (wake_req),
        .asleep (asleep)
    );

    // Low-voltage cause: set by supply event, cleared by firmware zero.
    always_ff @(posedge clk) begin
        if (!rst_n || lv_evt)            lowv_q <= 1'b1;
        else if (wr_en && !wr_data[B_LOWV]) lowv_q <= 1'b0;
    end

    // Watchdog cause: supply event clears it ahead of the rollover.
    always_ff @(posedge clk) begin
        if (!rst_n || lv_evt)            wdog_q <= 1'b0;
        else if (wdt_roll)               wdog_q <= 1'b1;
        else if (wr_en && !wr_data[B_WDOG]) wdog_q <= 1'b0;
    end

    // Bus event: a qualified event beats a firmware clear.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_rst)            buse_q <= 1'b0;
        else if (bus_fire)               buse_q <= 1'b1;
        else if (wr_en && !wr_data[B_BUSE]) buse_q <= 1'b0;
    end

    // Run flag: cleared by halt or a firmware zero, restored by resets.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_rst)                          run_q <= 1'b1;
        else if (halt_op || (wr_en && !wr_data[B_RUN])) run_q <= 1'b0;
    end

    // Assemble readback and outputs.
    always_comb begin
        rd_data         = '0;
        rd_data[B_PEND] = pend;
        rd_data[B_WDOG] = wdog_q;
        rd_data[B_BUSE] = buse_q;
        rd_data[B_LOWV] = lowv_q;
        rd_data[B_SUSP] = asleep;
        rd_data[B_IEN]  = ien;
        rd_data[B_RSVD] = 1'b0;
        rd_data[B_RUN]  = run_q;
        suspend_o       = asleep;
        run_o           = run_q;
    end

    // R3: supply event marks its own cause and clears the watchdog cause
    a_r3_lowv_cause: assert property (@(posedge clk) disable iff (!rst_n)
        lv_evt |=> (rd_data[B_LOWV] && !rd_data[B_WDOG]));
    // R2: rollover marks the watchdog cause
    a_r2_wdog_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_roll && !lv_evt) |=> rd_data[B_WDOG]);
    // R2: rollover leaves the low-voltage cause as it was
    a_r2_lowv_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_roll && !lv_evt) |=> (lowv_q == $past(lowv_q)));
    // R12: halt stops the core
    a_r12_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_op && !hw_rst) |=> !run_o);
    // R12: once halted, only a reset cause restarts the core
    a_r12_halt_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && !hw_rst) |=> !run_o);
endmodule

// File: tb/sysctl_status_tb.sv
// Bench for sysctl_status: directed corner cases with literal expectations,
// then seeded random traffic compared each cycle against a bench model
// written from the requirements.
module sysctl_status_tb;
    localparam int QT = 2;
    localparam int WS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic wdt_roll = 0, lv_evt = 0, bus_lvl = 0, tick_128 = 0;
    logic halt_op = 0, ei_op = 0, di_op = 0, reti_op = 0;
    logic irq_req = 0, src_en = 0, wake_req = 0;
    logic suspend_o, run_o, irq_ack;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // bench model state
    bit m_pend, m_wdr, m_bev, m_lvr, m_ien, m_run, m_ack;
    int m_q, m_st, m_cnt;

    always #4 clk = ~clk;

    sysctl_status #(.QUAL_TICKS(QT), .WAKE_CYCLES(WS)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .wdt_roll(wdt_roll), .lv_evt(lv_evt),
        .bus_lvl(bus_lvl), .tick_128(tick_128), .halt_op(halt_op),
        .ei_op(ei_op), .di_op(di_op), .reti_op(reti_op), .irq_req(irq_req),
        .src_en(src_en), .wake_req(wake_req), .suspend_o(suspend_o),
        .run_o(run_o), .irq_ack(irq_ack)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int model_rd();
        return (int'(m_pend) << 7) | (int'(m_wdr) << 6) | (int'(m_bev) << 5) |
               (int'(m_lvr) << 4) | (int'(m_st != 0) << 3) | (int'(m_ien) << 2) |
               int'(m_run);
    endfunction

    task automatic model_reset();
        m_pend = 0; m_wdr = 0; m_bev = 0; m_lvr = 1; m_ien = 0; m_run = 1;
        m_ack = 0; m_q = 0; m_st = 0; m_cnt = 0;
    endtask

    // next state from the requirements, using current inputs
    task automatic model_update();
        bit hr, take, fire;
        hr   = wdt_roll | lv_evt;
        take = m_pend & src_en & m_ien;
        fire = !hr && bus_lvl && tick_128 && (m_q == QT - 1);
        if (hr || !bus_lvl) m_q = 0;
        else if (tick_128 && m_q < QT) m_q = m_q + 1;
        if (lv_evt) m_lvr = 1; else if (wr_en && !wr_data[4]) m_lvr = 0;
        if (lv_evt) m_wdr = 0; else if (wdt_roll) m_wdr = 1;
        else if (wr_en && !wr_data[6]) m_wdr = 0;
        if (hr) m_bev = 0; else if (fire) m_bev = 1;
        else if (wr_en && !wr_data[5]) m_bev = 0;
        if (hr) m_run = 1; else if (halt_op || (wr_en && !wr_data[0])) m_run = 0;
        if (hr) m_pend = 0; else if (irq_req) m_pend = 1; else if (take) m_pend = 0;
        if (hr) m_ien = 0; else if (take || di_op) m_ien = 0;
        else if (ei_op || reti_op) m_ien = 1;
        m_ack = hr ? 0 : take;
        if (hr) begin
            m_st = 0; m_cnt = 0;
        end else if (m_st == 0) begin
            if (wr_en && wr_data[3]) m_st = 1;
        end else if (m_st == 1) begin
            if (wake_req) begin m_st = 2; m_cnt = WS - 1; end
        end else begin
            if (m_cnt == 0) m_st = 0; else m_cnt = m_cnt - 1;
        end
    endtask

    task automatic compare_all();
        chk("R7 pending bit", int'(rd_data[7]), int'(m_pend));
        chk("R2 watchdog bit", int'(rd_data[6]), int'(m_wdr));
        chk("R5 bus event bit", int'(rd_data[5]), int'(m_bev));
        chk("R3 low-voltage bit", int'(rd_data[4]), int'(m_lvr));
        chk("R10 suspend bit", int'(rd_data[3]), int'(m_st != 0));
        chk("R10 suspend_o", int'(suspend_o), int'(m_st != 0));
        chk("R9 enable sense", int'(rd_data[2]), int'(m_ien));
        chk("R4 reserved bit", int'(rd_data[1]), 0);
        chk("R12 run bit", int'(rd_data[0]), int'(m_run));
        chk("R12 run_o", int'(run_o), int'(m_run));
        chk("R8 irq_ack", int'(irq_ack), int'(m_ack));
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic cyc();
        @(posedge clk);
        #1;
        if (!rst_n) model_reset(); else model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic clear_pulses();
        wr_en = 0; wr_data = 8'h00; wdt_roll = 0; lv_evt = 0; tick_128 = 0;
        halt_op = 0; ei_op = 0; di_op = 0; reti_op = 0; irq_req = 0;
    endtask

    task automatic fw_write(input logic [7:0] d);
        wr_en = 1; wr_data = d; cyc(); clear_pulses();
    endtask

    // watchdog for a hung run
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int hi;
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        rst_n = 0;
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R1 reset state
        chk("R1 reset readback", int'(rd_data), 'h11);
        chk("R1 reset suspend_o", int'(suspend_o), 0);
        chk("R1 reset irq_ack", int'(irq_ack), 0);

        // R2 watchdog rollover
        wdt_roll = 1; cyc(); clear_pulses();
        chk("R2 rollover readback", int'(rd_data), 'h51);
        // R4 writing ones leaves sticky bits, ignores 7/2/1
        fw_write(8'hF7);
        chk("R4 write ones no effect", int'(rd_data), 'h51);
        fw_write(8'h01);
        chk("R4 write zeros clear", int'(rd_data), 'h01);
        // R3 supply event wins over rollover
        lv_evt = 1; wdt_roll = 1; cyc(); clear_pulses();
        chk("R3 both causes readback", int'(rd_data), 'h11);

        // R5 qualification with a gap, then two unbroken ticks
        bus_lvl = 1; tick_128 = 1; cyc(); clear_pulses();
        bus_lvl = 0; cyc();
        bus_lvl = 1; tick_128 = 1; cyc(); clear_pulses();
        chk("R5 gap restarts count", int'(rd_data[5]), 0);
        cyc();
        tick_128 = 1; cyc(); clear_pulses();
        chk("R5 latched on second tick", int'(rd_data[5]), 1);
        tick_128 = 1; fw_write(8'h11);
        chk("R5 no relatch while held", int'(rd_data[5]), 0);
        // R6 completion beats a same-cycle firmware clear
        bus_lvl = 0; cyc(); bus_lvl = 1;
        tick_128 = 1; cyc(); clear_pulses();
        tick_128 = 1; fw_write(8'h11);
        chk("R6 set beats clear", int'(rd_data[5]), 1);
        bus_lvl = 0; fw_write(8'h11);
        chk("R6 firmware clear", int'(rd_data), 'h11);

        // R7 pending held while not enabled
        src_en = 0; irq_req = 1; cyc(); clear_pulses();
        chk("R7 pending set", int'(rd_data), 'h91);
        src_en = 1; cyc(); cyc();
        chk("R7 held with global enable off", int'(rd_data), 'h91);
        // R8 take the interrupt
        ei_op = 1; cyc(); clear_pulses();
        chk("R9 enable instruction", int'(rd_data), 'h95);
        cyc();
        chk("R8 ack strobe", int'(irq_ack), 1);
        chk("R8 pending and enable cleared", int'(rd_data), 'h11);
        cyc();
        chk("R8 ack single cycle", int'(irq_ack), 0);

        // R9 enable sense rules
        src_en = 0;
        fw_write(8'h15);
        chk("R9 write to sense ignored", int'(rd_data), 'h11);
        ei_op = 1; di_op = 1; cyc(); clear_pulses();
        chk("R9 disable wins", int'(rd_data[2]), 0);
        reti_op = 1; cyc(); clear_pulses();
        chk("R9 return sets enable", int'(rd_data[2]), 1);
        di_op = 1; cyc(); clear_pulses();

        // R10 suspend and timed release
        fw_write(8'h19);
        chk("R10 suspend entered", int'(suspend_o), 1);
        repeat (3) cyc();
        chk("R10 held without wake", int'(rd_data), 'h19);
        wake_req = 1; cyc(); wake_req = 0;
        for (int i = 0; i < WS - 1; i++) cyc();
        chk("R10 still suspended before delay", int'(suspend_o), 1);
        cyc();
        chk("R10 released after delay", int'(suspend_o), 0);

        // R11 wake present at entry
        wake_req = 1;
        fw_write(8'h19);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            if (suspend_o) hi++;
            cyc();
        end
        chk("R11 suspend cycles with early wake", hi, WS + 1);
        wake_req = 0;

        // R12 halt and restart
        halt_op = 1; cyc(); clear_pulses();
        chk("R12 halt clears run", int'(run_o), 0);
        fw_write(8'h11);
        chk("R12 write one does not restart", int'(rd_data[0]), 0);
        wdt_roll = 1; cyc(); clear_pulses();
        chk("R12 rollover restarts", int'(rd_data), 'h51);

        // random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            lv_evt   = ($urandom % 300) == 0;
            wdt_roll = ($urandom % 200) == 0;
            wr_en    = ($urandom % 10) == 0;
            wr_data  = 8'($urandom);
            if (($urandom % 20) == 0) bus_lvl = ~bus_lvl;
            tick_128 = ($urandom % 3) == 0;
            halt_op  = ($urandom % 60) == 0;
            ei_op    = ($urandom % 8) == 0;
            di_op    = ($urandom % 12) == 0;
            reti_op  = ($urandom % 15) == 0;
            irq_req  = ($urandom % 10) == 0;
            if (($urandom % 15) == 0) src_en = ~src_en;
            wake_req = ($urandom % 10) == 0;
            cyc();
        end
        clear_pulses();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule